// File: doc/BRIEF.md
# Serial Audio Format Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, left/right frame clock, data) and turns it into parallel left and right samples in the system clock domain. All three link wires are brought through synchronizers. Data and frame clock are sampled on each rising bit clock edge. Once the right-channel word of a frame is complete, both channel words are presented together with a one-cycle valid strobe.

A static format input picks between the right-justified layout and the I2S layout. In right-justified mode the block counts bit clocks in every frame-clock half. When a frame carries exactly 16 bit clocks per half, it changes over to 16-bit packed capture for the frames that follow. The word that results is placed at the top of the `WORD_W`-bit output with zeros below it. A half that is too short for a word is reported as a framing error. The word width is a parameter and must be at least 16. The bit clock has to be slower than a quarter of the system clock rate.

Top module: `aud_serial_rx`

## Requirements
- R1: During and after reset, `left_o` and `right_o` are zero and `valid_o` and `frame_err_o` are low until a complete frame has been received.
- R2: With `fmt_i` = 0 (right-justified, MSB first), each channel word is made of the last `WORD_W` bits sampled before the frame clock changes level. Any leading bits in a longer half are ignored.
- R3: With `fmt_i` = 1 (I2S), the left channel is carried while the frame clock is low. The MSB is the bit taken on the second rising bit clock after a frame clock change. The first `WORD_W` bits form the word and any further bits in the slot are ignored.
- R4: With `fmt_i` = 0, the left channel is carried while the frame clock is high and the right channel while it is low.
- R5: In right-justified mode, the first frame with exactly 16 bit clocks in both halves produces no strobe and switches to packed capture. Each later such frame yields its 16-bit words in bits `WORD_W-1:WORD_W-16`, with the lower bits zero.
- R6: In right-justified mode, the first full-length frame after packed capture produces no strobe and restores full-width capture. Frames after it are captured normally.
- R7: `valid_o` is high for exactly one clock per accepted frame, after that frame's right word has ended. `left_o` and `right_o` change only in the cycle where `valid_o` is high.
- R8: A frame with a half shorter than `WORD_W` bit clocks (other than a 16-bit half in right-justified mode) pulses `frame_err_o` for one clock and gives no strobe. The outputs and the packing decision stay unchanged.
- R9: The partial half that is in progress when reset is released is never reported. The first strobe needs a left half that started at an observed frame clock change.
- R10: With `fmt_i` = 1, a frame with 16-bit halves is a framing error (when `WORD_W` > 16) and does not start packed capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 1 | Format select: 0 right-justified, 1 I2S |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Left/right frame clock |
| sdat_i | input | 1 | Serial data, MSB first |
| left_o | output | WORD_W | Left channel word of the last accepted frame |
| right_o | output | WORD_W | Right channel word of the last accepted frame |
| valid_o | output | 1 | One-cycle strobe when a frame is accepted |
| frame_err_o | output | 1 | One-cycle pulse when a frame is rejected as too short |

## Verification
The hardest situations to reach are the changeover frames, where the packing decision flips and exactly one frame must disappear without any error. A fixed sequence of right-justified frames steps from full-length to 16-bit halves and back, with a short frame in between. Each changeover therefore sits between frames whose words are known. In I2S mode the strobe fires inside the closing bit of the frame rather than at the start of the next one. For that reason every strobe is logged in order and matched against the expected list, instead of being tied to a fixed bit position.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic {
    FMT_RJ  = 1'b0,
    FMT_I2S = 1'b1
  } fmt_e;

  localparam int unsigned PACK_W = 16;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrck_i,
  input  logic sdat_i,
  output logic tick_o,
  output logic lrck_o,
  output logic sdat_o
);
  logic [STAGES-1:0] bclk_q, lrck_q, sdat_q;
  logic              bclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= '0;
      lrck_q <= '0;
      sdat_q <= '0;
      bclk_d <= 1'b0;
    end else begin
      bclk_q <= {bclk_q[STAGES-2:0], bclk_i};
      lrck_q <= {lrck_q[STAGES-2:0], lrck_i};
      sdat_q <= {sdat_q[STAGES-2:0], sdat_i};
      bclk_d <= bclk_q[STAGES-1];
    end
  end

  assign tick_o = bclk_q[STAGES-1] & ~bclk_d;
  assign lrck_o = lrck_q[STAGES-1];
  assign sdat_o = sdat_q[STAGES-1];

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R7
endmodule

// File: rtl/aud_rx_halfcnt.sv
module aud_rx_halfcnt #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             lrck_i,
  output logic             half_end_o,
  output logic             old_lrck_o,
  output logic [CNT_W-1:0] half_len_o
);
  logic             lrck_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_full;

  assign cnt_full   = &cnt_q;
  assign half_end_o = tick_i & (lrck_i != lrck_q);
  assign old_lrck_o = lrck_q;
  assign half_len_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tick_i) begin
      lrck_q <= lrck_i;
      if (half_end_o)    cnt_q <= CNT_W'(1);
      else if (!cnt_full) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !half_end_o) |=> (cnt_q >= $past(cnt_q))); // R8
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
  import aud_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              packed_i,
  input  logic              tick_i,
  input  logic              sdat_i,
  input  logic              half_end_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned IDX_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] acc_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] rj_pk, rj_word, i2s_word;
  logic              acc_open;

  // Right-justified: the newest bits sit at the bottom of the shift register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (tick_i) sh_q <= {sh_q[WORD_W-2:0], sdat_i};
  end

  generate
    if (WORD_W > PACK_W) begin : g_pack_pad
      assign rj_pk = {sh_q[PACK_W-1:0], {(WORD_W-PACK_W){1'b0}}};
    end else begin : g_pack_same
      assign rj_pk = sh_q;
    end
  endgenerate

  assign rj_word = packed_i ? rj_pk : sh_q;

  // I2S: collect the first WORD_W bits after the edge that carries the frame clock change
  assign acc_open = idx_q < IDX_W'(WORD_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (tick_i) begin
      if (half_end_i) begin
        acc_q <= '0;
        idx_q <= '0;
      end else if (acc_open) begin
        acc_q <= {acc_q[WORD_W-2:0], sdat_i};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign i2s_word = acc_open ? {acc_q[WORD_W-2:0], sdat_i} : acc_q;
  assign word_o   = (fmt_e'(fmt_i) == FMT_I2S) ? i2s_word : rj_word;

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(WORD_W)); // R3
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned MAX_HALF    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic              sdat_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int unsigned CNT_W = $clog2(MAX_HALF + 1);

  logic             tick, lrck_s, sdat_s;
  logic             half_end, old_lrck;
  logic [CNT_W-1:0] half_len;
  logic [WORD_W-1:0] word;

  logic              armed_q, left_ok_q, l_short_q, l16_q, packed_q;
  logic [WORD_W-1:0] left_hold_q;
  logic              is_rj, ending_left, half_is16, half_short;
  logic              frame_bad, frame_pk;

  aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .bclk_i(bclk_i), .lrck_i(lrck_i), .sdat_i(sdat_i),
    .tick_o(tick), .lrck_o(lrck_s), .sdat_o(sdat_s)
  );

  aud_rx_halfcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_i(tick), .lrck_i(lrck_s),
    .half_end_o(half_end), .old_lrck_o(old_lrck), .half_len_o(half_len)
  );

  aud_rx_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fmt_i(fmt_i), .packed_i(packed_q),
    .tick_i(tick), .sdat_i(sdat_s), .half_end_i(half_end),
    .word_o(word)
  );

  assign is_rj       = fmt_e'(fmt_i) == FMT_RJ;
  // right-justified: left while high; I2S: left while low
  assign ending_left = old_lrck ^ fmt_i;
  assign half_is16   = half_len == CNT_W'(PACK_W);
  assign half_short  = (half_len < CNT_W'(WORD_W)) && !(is_rj && half_is16);
  assign frame_bad   = l_short_q | half_short;
  assign frame_pk    = is_rj & l16_q & half_is16;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b0;
      left_ok_q   <= 1'b0;
      l_short_q   <= 1'b0;
      l16_q       <= 1'b0;
      packed_q    <= 1'b0;
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      if (half_end) begin
        armed_q <= 1'b1;
        if (ending_left) begin
          left_ok_q   <= armed_q;
          left_hold_q <= word;
          l_short_q   <= half_short;
          l16_q       <= half_is16;
        end else begin
          left_ok_q <= 1'b0;
          if (left_ok_q) begin
            if (frame_bad) begin
              frame_err_o <= 1'b1;
            end else begin
              packed_q <= frame_pk;
              // a frame that flips the packing decision is dropped
              if (frame_pk == packed_q) begin
                valid_o <= 1'b1;
                left_o  <= left_hold_q;
                right_o <= word;
              end
            end
          end
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_VALID_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(half_end)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7
  AST_ERR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !valid_o); // R8
  AST_ERR_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> $past(half_end)); // R8
endmodule

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;
  localparam int CLK_P  = 10;
  localparam int BHALF  = 4;
  localparam int WORD_W = 24;

  typedef struct packed {
    logic [7:0]  bph;
    logic [23:0] lv;
    logic [23:0] rv;
    logic        ev;
    logic [23:0] el;
    logic [23:0] er;
    logic [3:0]  tag;
  } vec_t;

  localparam vec_t RJ_TAB [9] = '{
    '{8'd32, 24'h123456, 24'hABCDEF, 1'b1, 24'h123456, 24'hABCDEF, 4'd2},  // R2 R4
    '{8'd24, 24'h800001, 24'h7FFFFE, 1'b1, 24'h800001, 24'h7FFFFE, 4'd2},
    '{8'd16, 24'h00BEEF, 24'h001234, 1'b0, 24'h0,      24'h0,      4'd5},  // R5 dropped
    '{8'd16, 24'h00CAFE, 24'h000F0F, 1'b1, 24'hCAFE00, 24'h0F0F00, 4'd5},
    '{8'd16, 24'h008001, 24'h00FFFF, 1'b1, 24'h800100, 24'hFFFF00, 4'd5},
    '{8'd32, 24'h999999, 24'h888888, 1'b0, 24'h0,      24'h0,      4'd6},  // R6 dropped
    '{8'd32, 24'h000001, 24'hFFFFFE, 1'b1, 24'h000001, 24'hFFFFFE, 4'd6},
    '{8'd12, 24'h000ABC, 24'h000DEF, 1'b0, 24'h0,      24'h0,      4'd8},  // R8 error
    '{8'd32, 24'h5A5A5A, 24'hA5A5A5, 1'b1, 24'h5A5A5A, 24'hA5A5A5, 4'd8}
  };

  localparam vec_t I2S_TAB [4] = '{
    '{8'd32, 24'h123456, 24'h654321, 1'b1, 24'h123456, 24'h654321, 4'd3},  // R3
    '{8'd24, 24'hFEDCBA, 24'h000001, 1'b1, 24'hFEDCBA, 24'h000001, 4'd3},
    '{8'd16, 24'h00AAAA, 24'h005555, 1'b0, 24'h0,      24'h0,      4'd10}, // R10 error
    '{8'd32, 24'h111111, 24'h222222, 1'b1, 24'h111111, 24'h222222, 4'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt = 1'b0, bclk = 1'b0, lrck = 1'b0, sdat = 1'b0;
  logic [WORD_W-1:0] left, right;
  logic valid, ferr;

  int checks = 0, errors = 0;
  int ev_n, err_n, hold_viol, pulse_viol;
  logic [23:0] ev_l [32];
  logic [23:0] ev_r [32];
  logic [23:0] prev_l, prev_r;
  logic prev_v;

  always #(CLK_P/2) clk = ~clk;

  aud_serial_rx #(.WORD_W(WORD_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt),
    .bclk_i(bclk), .lrck_i(lrck), .sdat_i(sdat),
    .left_o(left), .right_o(right), .valid_o(valid), .frame_err_o(ferr)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      ev_n = 0; err_n = 0; hold_viol = 0; pulse_viol = 0;
      prev_l = '0; prev_r = '0; prev_v = 1'b0;
    end else begin
      if (valid) begin
        if (ev_n < 32) begin ev_l[ev_n] = left; ev_r[ev_n] = right; end
        ev_n++;
      end
      if (ferr) err_n++;
      if (!valid && (left != prev_l || right != prev_r)) hold_viol++;
      if (valid && prev_v) pulse_viol++;
      prev_l = left; prev_r = right; prev_v = valid;
    end
  end

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd8:    return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bit_out(input logic lr, input logic d);
    @(negedge clk);
    bclk = 1'b0; lrck = lr; sdat = d;
    repeat (BHALF) @(negedge clk);
    bclk = 1'b1;
    repeat (BHALF - 1) @(negedge clk);
  endtask

  task automatic rj_half(input logic lr, input int nb, input logic [23:0] v);
    for (int i = 0; i < nb; i++) begin
      int p = nb - 1 - i;
      bit_out(lr, (p < 24) ? v[p] : 1'b1);
    end
  endtask

  task automatic i2s_slot(input logic lv, input logic nxt, input int nb, input logic [23:0] v);
    for (int j = 0; j < nb; j++)
      bit_out((j == nb - 1) ? nxt : lv, (j < 24) ? v[23 - j] : 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bclk = 1'b0; lrck = 1'b0; sdat = 1'b0;
    repeat (4) @(negedge clk);
    chk(left == '0 && right == '0, "R1", "outputs in reset", {8'h0, left}, 32'h0);
    chk(!valid && !ferr, "R1", "strobes in reset", {30'h0, valid, ferr}, 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(left == '0 && right == '0 && !valid, "R1", "idle after reset", {8'h0, right}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k;
    // right-justified pass
    fmt = 1'b0;
    do_reset();
    rj_half(1'b0, 8, 24'h0);  // partial half before first change, R9
    chk(ev_n == 0, "R9", "no strobe from partial half", ev_n, 0);
    for (int i = 0; i < 9; i++) begin
      rj_half(1'b1, int'(RJ_TAB[i].bph), RJ_TAB[i].lv);
      rj_half(1'b0, int'(RJ_TAB[i].bph), RJ_TAB[i].rv);
    end
    rj_half(1'b1, 24, 24'h0);  // closing edge ends the last right half
    repeat (20) @(negedge clk);
    k = 0;
    for (int i = 0; i < 9; i++) begin
      if (RJ_TAB[i].ev) begin
        chk(ev_l[k] == RJ_TAB[i].el, tag_name(RJ_TAB[i].tag), "rj left word", {8'h0, ev_l[k]}, {8'h0, RJ_TAB[i].el});
        chk(ev_r[k] == RJ_TAB[i].er, tag_name(RJ_TAB[i].tag), "rj right word", {8'h0, ev_r[k]}, {8'h0, RJ_TAB[i].er});
        k++;
      end
    end
    chk(ev_n == k, "R5", "rj strobe count with dropped changeover frames", ev_n, k);
    chk(err_n == 1, "R8", "rj framing error pulses", err_n, 1);
    chk(hold_viol == 0, "R7", "rj outputs held between strobes", hold_viol, 0);
    chk(pulse_viol == 0, "R7", "rj strobe width", pulse_viol, 0);

    // I2S pass
    fmt = 1'b1;
    do_reset();
    i2s_slot(1'b1, 1'b0, 8, 24'h0);  // partial slot, R9
    chk(ev_n == 0, "R9", "no strobe from i2s preamble", ev_n, 0);
    for (int i = 0; i < 4; i++) begin
      i2s_slot(1'b0, 1'b1, int'(I2S_TAB[i].bph), I2S_TAB[i].lv);
      i2s_slot(1'b1, 1'b0, int'(I2S_TAB[i].bph), I2S_TAB[i].rv);
    end
    repeat (20) @(negedge clk);
    k = 0;
    for (int i = 0; i < 4; i++) begin
      if (I2S_TAB[i].ev) begin
        chk(ev_l[k] == I2S_TAB[i].el, tag_name(I2S_TAB[i].tag), "i2s left word", {8'h0, ev_l[k]}, {8'h0, I2S_TAB[i].el});
        chk(ev_r[k] == I2S_TAB[i].er, tag_name(I2S_TAB[i].tag), "i2s right word", {8'h0, ev_r[k]}, {8'h0, I2S_TAB[i].er});
        k++;
      end
    end
    chk(ev_n == k, "R3", "i2s strobe count", ev_n, k);
    chk(err_n == 1, "R10", "i2s 16-bit frame flagged", err_n, 1);
    chk(hold_viol == 0, "R7", "i2s outputs held between strobes", hold_viol, 0);
    chk(pulse_viol == 0, "R7", "i2s strobe width", pulse_viol, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule